// File: doc/BRIEF.md
# Control Pipe Handshake and Sequence Register

This block is the 16-bit control and status word of the default control pipe in a USB controller that can act as host or as peripheral. Software reaches it over a simple synchronous register bus. The word holds the handshake the pipe answers with and the DATA0/DATA1 sequence toggle. In host mode it carries the request to launch a SETUP transaction. In peripheral mode it records that software has closed the control transfer. The protocol engine feeds it events: a SETUP token arrived, a SETUP transaction went out, a data transaction was acknowledged, or a transaction failed. These events override what software wrote.

Internally the block runs three small state machines. The toggle machine has the states TG_DATA0 and TG_DATA1:
- It moves to TG_DATA1 on a peripheral-mode SETUP.
- It swaps state on every acknowledged transaction.
- It follows a software clear or set command when that command is allowed.

The SETUP request machine has the states SRQ_IDLE and SRQ_PEND:
- It moves from SRQ_IDLE to SRQ_PEND on a host-mode write of 1 to the request bit.
- It returns to SRQ_IDLE when the SETUP transaction has been sent.

The control-transfer machine has the states CT_IDLE, CT_DATA and CT_STATUS:
- A peripheral-mode SETUP moves it from any state to CT_DATA.
- A peripheral-mode write of 1 to the complete bit moves it from CT_IDLE or CT_DATA to CT_STATUS.
- It stays in CT_STATUS until the next SETUP.

The response code is a plain 2-bit field. Hardware overrides it on errors and on SETUP reception.

Top module: `ctlpipe_hs_reg`

## Requirements
- R1: A read with `addr_i` equal to `REG_ADDR` returns the following, and every other bit reads 0. A read at any other address returns 0.
  - bit 15: `buf_en_i`
  - bit 14: the SETUP request state
  - bit 6: the toggle (0 = DATA0, 1 = DATA1)
  - bits 1:0: the response code
  - bits 8, 7 and 2 are write-only command bits and always read 0.
- R2: After reset the response code is 00 (NAK), the toggle is DATA0, and `setup_req_o` and `stage_cpl_o` are 0.
- R3: A write (`wr_i` high, address matching) loads `wdata_i[1:0]` into the response code on the next cycle when no event overrides it. The codes are 00 NAK, 01 answer from buffer state, and 10 or 11 STALL; both STALL codes read back as written. A write to any other address changes nothing.
- R4: With the current response code at 00, writing 1 to bit 8 makes the toggle DATA0 and writing 1 to bit 7 makes it DATA1 on the next cycle. Writing 0 to either bit leaves the toggle unchanged.
- R5: A write carrying 1 in both bit 8 and bit 7 leaves the toggle unchanged. So does any toggle write made while the response code held before the write is not 00.
- R6: In host mode, writing 1 to bit 14 raises `setup_req_o` on the next cycle. Writing 0 to bit 14 never lowers it. In peripheral mode the bit ignores writes.
- R7: While `setup_req_o` is high, `setup_tx_done_i` lowers it on the next cycle. This holds even if the same cycle writes 1 to bit 14.
- R8: In peripheral mode, `setup_rx_i` sets the response code to 00, the toggle to DATA1 and `stage_cpl_o` to 0 on the next cycle. It overrides any software write in the same cycle. In host mode `setup_rx_i` is ignored.
- R9: In peripheral mode, writing 1 to bit 2 raises `stage_cpl_o` on the next cycle, and the output stays high until the next SETUP is received. Writing 0 to bit 2 has no effect. In host mode the bit ignores writes.
- R10: `txn_err_i` sets the response code to 10 (STALL) on the next cycle. It takes priority over `setup_rx_i` and over a software write.
- R11: `txn_ack_i` inverts the toggle on the next cycle and overrides a software toggle command. A peripheral-mode `setup_rx_i` in the same cycle takes priority over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_mode_i | input | 1 | 1 = host mode, 0 = peripheral mode |
| addr_i | input | ADDR_W | Register bus address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data (combinational) |
| setup_rx_i | input | 1 | SETUP token received |
| setup_tx_done_i | input | 1 | SETUP transaction sent |
| txn_ack_i | input | 1 | Data transaction acknowledged |
| txn_err_i | input | 1 | Transaction error |
| buf_en_i | input | 1 | Buffer access enabled |
| resp_o | output | 2 | Current response code |
| toggle_o | output | 1 | Current sequence toggle |
| setup_req_o | output | 1 | SETUP transmission requested |
| stage_cpl_o | output | 1 | Control transfer ended by software |

## Verification
Several pairs of functions can land in the same cycle, and the bench makes them collide on purpose:
- a SETUP reception and a software write to the response code or toggle;
- an error and a SETUP reception;
- an acknowledge and a software toggle command;
- a SETUP-sent event and a fresh request write.

The sweep walks every combination of mode, the four events, the write strobe, the address match and six meaningful write-data bits. Each combination appears in a different state history. A reference model applies the stated priority order, and every output plus the read word is compared against it on each cycle. In each colliding case, the field must take the value of the winning source and none of the loser's effect.

// File: rtl/ctlpipe_pkg.sv
package ctlpipe_pkg;

    localparam int REG_W     = 16;
    localparam int BIT_BUF   = 15;
    localparam int BIT_SREQ  = 14;
    localparam int BIT_TCLR  = 8;
    localparam int BIT_TSET  = 7;
    localparam int BIT_TMON  = 6;
    localparam int BIT_CCPL  = 2;
    localparam int RESP_W    = 2;

    localparam logic [RESP_W-1:0] RESP_NAK   = 2'b00;
    localparam logic [RESP_W-1:0] RESP_BUF   = 2'b01;
    localparam logic [RESP_W-1:0] RESP_STALL = 2'b10;

    typedef struct packed {
        logic              wr;
        logic [RESP_W-1:0] resp;
        logic              tclr;
        logic              tset;
        logic              sreq;
        logic              ccpl;
    } sw_wr_t;

    typedef struct packed {
        logic setup_rx;
        logic setup_tx;
        logic ack;
        logic err;
    } hw_ev_t;

    typedef enum logic {
        TG_DATA0 = 1'b0,
        TG_DATA1 = 1'b1
    } tog_state_t;

    typedef enum logic {
        SRQ_IDLE = 1'b0,
        SRQ_PEND = 1'b1
    } sreq_state_t;

    typedef enum logic [1:0] {
        CT_IDLE   = 2'b00,
        CT_DATA   = 2'b01,
        CT_STATUS = 2'b10
    } ct_state_t;

endpackage

// File: rtl/ctlpipe_decode.sv
module ctlpipe_decode
    import ctlpipe_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic              hit_o,
    output sw_wr_t            sw_o
);

    always_comb begin
        hit_o      = (addr_i == REG_ADDR);
        sw_o.wr    = wr_i && hit_o;
        sw_o.resp  = wdata_i[RESP_W-1:0];
        sw_o.tclr  = sw_o.wr && wdata_i[BIT_TCLR];
        sw_o.tset  = sw_o.wr && wdata_i[BIT_TSET];
        sw_o.sreq  = sw_o.wr && wdata_i[BIT_SREQ];
        sw_o.ccpl  = sw_o.wr && wdata_i[BIT_CCPL];
    end

endmodule

// File: rtl/ctlpipe_seq.sv
module ctlpipe_seq
    import ctlpipe_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  sw_wr_t            sw_i,
    input  hw_ev_t            ev_i,
    output logic [RESP_W-1:0] resp_o,
    output logic              toggle_o
);

    logic [RESP_W-1:0] resp_q, resp_d;
    tog_state_t        tog_q, tog_d;
    logic              tog_cmd_ok;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            resp_q <= RESP_NAK;
            tog_q  <= TG_DATA0;
        end else begin
            resp_q <= resp_d;
            tog_q  <= tog_d;
        end
    end

    always_comb begin
        if (ev_i.err) begin
            resp_d = RESP_STALL;
        end else if (ev_i.setup_rx) begin
            resp_d = RESP_NAK;
        end else if (sw_i.wr) begin
            resp_d = sw_i.resp;
        end else begin
            resp_d = resp_q;
        end
    end

    always_comb begin
        tog_cmd_ok = (resp_q == RESP_NAK) && (sw_i.tclr != sw_i.tset);
        tog_d      = tog_q;
        if (ev_i.setup_rx) begin
            tog_d = TG_DATA1;
        end else begin
            unique case (tog_q)
                TG_DATA0: begin
                    if (ev_i.ack) begin
                        tog_d = TG_DATA1;
                    end else if (tog_cmd_ok && sw_i.tset) begin
                        tog_d = TG_DATA1;
                    end
                end
                TG_DATA1: begin
                    if (ev_i.ack) begin
                        tog_d = TG_DATA0;
                    end else if (tog_cmd_ok && sw_i.tclr) begin
                        tog_d = TG_DATA0;
                    end
                end
                default: tog_d = TG_DATA0;
            endcase
        end
    end

    always_comb begin
        resp_o   = resp_q;
        toggle_o = (tog_q == TG_DATA1);
    end

endmodule

// File: rtl/ctlpipe_phase.sv
module ctlpipe_phase
    import ctlpipe_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   host_mode_i,
    input  sw_wr_t sw_i,
    input  hw_ev_t ev_i,
    output logic   setup_req_o,
    output logic   stage_cpl_o
);

    sreq_state_t srq_q, srq_d;
    ct_state_t   ct_q, ct_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            srq_q <= SRQ_IDLE;
            ct_q  <= CT_IDLE;
        end else begin
            srq_q <= srq_d;
            ct_q  <= ct_d;
        end
    end

    always_comb begin
        srq_d = srq_q;
        unique case (srq_q)
            SRQ_IDLE: if (host_mode_i && sw_i.sreq) srq_d = SRQ_PEND;
            SRQ_PEND: if (ev_i.setup_tx) srq_d = SRQ_IDLE;
            default:  srq_d = SRQ_IDLE;
        endcase
    end

    always_comb begin
        ct_d = ct_q;
        unique case (ct_q)
            CT_IDLE, CT_DATA: begin
                if (ev_i.setup_rx) begin
                    ct_d = CT_DATA;
                end else if (!host_mode_i && sw_i.ccpl) begin
                    ct_d = CT_STATUS;
                end
            end
            CT_STATUS: if (ev_i.setup_rx) ct_d = CT_DATA;
            default:   ct_d = CT_IDLE;
        endcase
    end

    always_comb begin
        setup_req_o = (srq_q == SRQ_PEND);
        stage_cpl_o = (ct_q == CT_STATUS);
    end

endmodule

// File: rtl/ctlpipe_hs_reg.sv
module ctlpipe_hs_reg
    import ctlpipe_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              host_mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    input  logic              setup_rx_i,
    input  logic              setup_tx_done_i,
    input  logic              txn_ack_i,
    input  logic              txn_err_i,
    input  logic              buf_en_i,
    output logic [RESP_W-1:0] resp_o,
    output logic              toggle_o,
    output logic              setup_req_o,
    output logic              stage_cpl_o
);

    logic   hit;
    sw_wr_t sw;
    hw_ev_t ev;

    always_comb begin
        ev.setup_rx = setup_rx_i && !host_mode_i;
        ev.setup_tx = setup_tx_done_i;
        ev.ack      = txn_ack_i;
        ev.err      = txn_err_i;
    end

    ctlpipe_decode #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_decode (
        .addr_i  (addr_i),
        .wr_i    (wr_i),
        .wdata_i (wdata_i),
        .hit_o   (hit),
        .sw_o    (sw)
    );

    ctlpipe_seq u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sw_i     (sw),
        .ev_i     (ev),
        .resp_o   (resp_o),
        .toggle_o (toggle_o)
    );

    ctlpipe_phase u_phase (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .host_mode_i (host_mode_i),
        .sw_i        (sw),
        .ev_i        (ev),
        .setup_req_o (setup_req_o),
        .stage_cpl_o (stage_cpl_o)
    );

    always_comb begin
        rdata_o = '0;
        if (hit) begin
            rdata_o[BIT_BUF]        = buf_en_i;
            rdata_o[BIT_SREQ]       = setup_req_o;
            rdata_o[BIT_TMON]       = toggle_o;
            rdata_o[RESP_W-1:0]     = resp_o;
        end
    end

endmodule

// File: rtl/ctlpipe_hs_reg_chk.sv
module ctlpipe_hs_reg_chk
    import ctlpipe_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              host_mode_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_i,
    input logic [REG_W-1:0]  wdata_i,
    input logic [REG_W-1:0]  rdata_o,
    input logic              setup_rx_i,
    input logic              setup_tx_done_i,
    input logic              txn_ack_i,
    input logic              txn_err_i,
    input logic              buf_en_i,
    input logic [RESP_W-1:0] resp_o,
    input logic              toggle_o,
    input logic              setup_req_o,
    input logic              stage_cpl_o
);

    AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rdata_o & 16'h3FBC) == 16'h0000); // R1

    AST_ERR_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        txn_err_i |=> resp_o == RESP_STALL); // R10

    AST_SETUP_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!host_mode_i && setup_rx_i && !txn_err_i)
        |=> (resp_o == RESP_NAK) && toggle_o && !stage_cpl_o); // R8

    AST_SREQ_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (setup_req_o && setup_tx_done_i) |=> !setup_req_o); // R7

    AST_ACK_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (txn_ack_i && (host_mode_i || !setup_rx_i))
        |=> toggle_o != $past(toggle_o)); // R11

    AST_TOG_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!txn_ack_i && (host_mode_i || !setup_rx_i) && resp_o != RESP_NAK)
        |=> $stable(toggle_o)); // R5

    AST_SREQ_PERIPH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!host_mode_i && !setup_req_o) |=> !setup_req_o); // R6

    AST_CCPL_HOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_mode_i && !stage_cpl_o) |=> !stage_cpl_o); // R9

endmodule

bind ctlpipe_hs_reg ctlpipe_hs_reg_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/ctlpipe_hs_reg_bench.sv
`timescale 1ns/1ps
module ctlpipe_hs_reg_bench;

    localparam int         ADDR_W = 8;
    localparam logic [7:0] RADDR  = 8'h10;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        host_mode_i = 1'b0;
    logic [7:0]  addr_i = '0;
    logic        wr_i = 1'b0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        setup_rx_i = 1'b0;
    logic        setup_tx_done_i = 1'b0;
    logic        txn_ack_i = 1'b0;
    logic        txn_err_i = 1'b0;
    logic        buf_en_i = 1'b0;
    logic [1:0]  resp_o;
    logic        toggle_o;
    logic        setup_req_o;
    logic        stage_cpl_o;

    int checks = 0;
    int errors = 0;

    logic [1:0] m_resp;
    logic       m_tog, m_sreq, m_cpl;

    always #2.5 clk_i = ~clk_i;

    ctlpipe_hs_reg #(.ADDR_W(ADDR_W), .REG_ADDR(RADDR)) u_ctlpipe_hs_reg (
        .clk_i(clk_i), .rst_ni(rst_ni), .host_mode_i(host_mode_i),
        .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .setup_rx_i(setup_rx_i), .setup_tx_done_i(setup_tx_done_i),
        .txn_ack_i(txn_ack_i), .txn_err_i(txn_err_i), .buf_en_i(buf_en_i),
        .resp_o(resp_o), .toggle_o(toggle_o), .setup_req_o(setup_req_o),
        .stage_cpl_o(stage_cpl_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic        ok, prx;
        logic [15:0] exp_rd;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        m_resp = 2'b00; m_tog = 1'b0; m_sreq = 1'b0; m_cpl = 1'b0;
        chk("R2 resp reset", resp_o, 0);
        chk("R2 toggle reset", toggle_o, 0);
        chk("R2 setup_req reset", setup_req_o, 0);
        chk("R2 stage_cpl reset", stage_cpl_o, 0);

        for (int i = 0; i < 8192; i++) begin
            @(negedge clk_i);
            chk("R3 R8 R10 resp", resp_o, m_resp);
            chk("R4 R5 R8 R11 toggle", toggle_o, m_tog);
            chk("R6 R7 setup_req", setup_req_o, m_sreq);
            chk("R8 R9 stage_cpl", stage_cpl_o, m_cpl);

            host_mode_i     = i[0];
            setup_rx_i      = i[1];
            setup_tx_done_i = i[2];
            txn_ack_i       = i[3];
            txn_err_i       = i[4];
            wr_i            = i[5];
            wdata_i         = '0;
            wdata_i[14]     = i[6];
            wdata_i[8]      = i[7];
            wdata_i[7]      = i[8];
            wdata_i[2]      = i[9];
            wdata_i[1:0]    = i[11:10];
            wdata_i[13:9]   = 5'h1F;
            wdata_i[5:3]    = 3'h7;
            addr_i          = i[12] ? (RADDR ^ 8'h04) : RADDR;
            buf_en_i        = i[2] ^ i[7];
            #1;

            ok = !i[12];
            exp_rd = '0;
            if (ok) begin
                exp_rd[15]  = buf_en_i;
                exp_rd[14]  = m_sreq;
                exp_rd[6]   = m_tog;
                exp_rd[1:0] = m_resp;
            end
            chk("R1 read word", rdata_o, exp_rd);

            ok  = wr_i && ok;
            prx = setup_rx_i && !host_mode_i;
            // R10 > R8 > R3 for the response code
            if (txn_err_i)  m_resp = 2'b10;
            else if (prx)   m_resp = 2'b00;
            else if (ok)    m_resp = wdata_i[1:0];
            // toggle guard uses the code held before this write (R4, R5)
            if (prx)            m_tog = 1'b1;
            else if (txn_ack_i) m_tog = ~m_tog;
            else if (ok && (exp_rd[1:0] == 2'b00) && (wdata_i[8] ^ wdata_i[7]))
                m_tog = wdata_i[7];
            if (m_sreq) m_sreq = !setup_tx_done_i;
            else        m_sreq = ok && host_mode_i && wdata_i[14];
            if (prx)                                m_cpl = 1'b0;
            else if (ok && !host_mode_i && wdata_i[2]) m_cpl = 1'b1;
        end
        @(negedge clk_i);
        chk("R3 R10 final resp", resp_o, m_resp);
        chk("R11 final toggle", toggle_o, m_tog);
        summary();
    end

endmodule